// File: doc/BRIEF.md
# Pipelined Row Dot-Product Engine

This block computes one element of a square-matrix-by-vector product at a time. Matrix coefficients stream in from off-chip storage, one 32-bit unsigned word per cycle when `mat_valid_i` is high. For each accepted coefficient the block fetches the matching vector word from an on-chip single-port RAM through its own address port, then sends the operand pair into a six-stage multiplier. That multiplier starts a new pair on every cycle.

Each full 64-bit product goes to a running 64-bit accumulator that wraps on overflow. The row index is not an input. An internal counter steps the vector address once per accepted coefficient and marks every N-th element as the end of a row. That end-of-row mark travels through the multiplier latency together with a valid bit. When the final product of a row is added, the sum is presented for one cycle and the accumulator starts the next row from zero, so rows can follow each other with no idle cycles. A synchronous clear empties the whole pipeline and restarts the row.

The vector RAM is read asynchronously: `vec_data_i` must hold the word at `vec_addr_o` in the same cycle.

Top module: `mvm_row_mac`

## Requirements
- R1: While `rst_ni` is low, `result_valid_o` is 0, `result_o` is 0 and `vec_addr_o` is 0.
- R2: `vec_addr_o` advances by one on each accepted coefficient, where accepted means `mat_valid_i` high and `clear_i` low. It goes from N-1 back to 0. It holds its value in every cycle where nothing is accepted.
- R3: The value reported for a row is the sum over the row's N accepted coefficients of the full unsigned 64-bit product of the coefficient and the vector word read with it, taken modulo 2^64.
- R4: `result_valid_o` is high for exactly one cycle per row. Count the rising edge that accepts the row's last coefficient as edge 1; `result_valid_o` is high in the cycle after edge 7.
- R5: Rows sent back to back, with no idle cycle between them, each give their own sum. The accumulator restarts from zero after every row.
- R6: Idle cycles inside a row (`mat_valid_i` low) add nothing to the sum and do not move the row boundary.
- R7: On an edge with `clear_i` high, four things happen. The accumulator is zeroed. `vec_addr_o` returns to 0. Every product still in flight is discarded and never gives a `result_valid_o` pulse. A coefficient offered in the same cycle is ignored.
- R8: Sums that pass 2^64 wrap. This includes all-ones operands on every element.
- R9: `result_o` changes only in a cycle where `result_valid_o` is high, and keeps the last reported sum otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous flush of accumulator, address and pipeline |
| mat_valid_i | input | 1 | Matrix coefficient present |
| mat_data_i | input | 32 | Matrix coefficient, unsigned |
| vec_addr_o | output | $clog2(N) | Vector RAM read address |
| vec_data_i | input | 32 | Vector RAM read data for `vec_addr_o`, same cycle |
| result_valid_o | output | 1 | One-cycle pulse marking a finished row |
| result_o | output | 64 | Row sum, held between pulses |

## Verification
The assertions check these properties on every cycle: the address stepping, holding and wrapping; the reset and clear behaviour of the address and the result pulse; the pulse lasting one cycle; and `result_o` staying stable between pulses. The numeric sums, the seven-edge latency, the separation of back-to-back rows, the effect of idle cycles and the discarding of in-flight products on clear can only be shown by the bench scenarios. In those scenarios every reported row is compared against a sum and an arrival cycle that the bench works out itself.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef struct packed {
    logic valid;
    logic last;
  } side_t;
endpackage

// File: rtl/mvm_addr_ctr.sv
module mvm_addr_ctr #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_end_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

  logic [AW-1:0] addr_q;

  assign at_end_o = (addr_q == LAST_IDX);
  assign addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clear_i) addr_q <= '0;
    else if (step_i)  addr_q <= at_end_o ? '0 : addr_q + 1'b1;
  end
endmodule

// File: rtl/mvm_mul_pipe.sv
// Unsigned W x W multiplier, STAGES registers deep (STAGES >= 3):
// operand regs, half-width partial products, combine, then plain delay.
module mvm_mul_pipe #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H     = W / 2;
  localparam int unsigned PW    = 2 * W;
  localparam int unsigned DEPTH = STAGES - 2;

  logic [W-1:0]  a_q, b_q;
  logic [W-1:0]  pp_ll, pp_lh, pp_hl, pp_hh;
  logic [PW-1:0] pipe_q [DEPTH];
  logic [PW-1:0] combined;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_ll <= '0;
      pp_lh <= '0;
      pp_hl <= '0;
      pp_hh <= '0;
    end else begin
      pp_ll <= W'(a_q[H-1:0]) * W'(b_q[H-1:0]);
      pp_lh <= W'(a_q[H-1:0]) * W'(b_q[W-1:H]);
      pp_hl <= W'(a_q[W-1:H]) * W'(b_q[H-1:0]);
      pp_hh <= W'(a_q[W-1:H]) * W'(b_q[W-1:H]);
    end
  end

  assign combined = (PW'(pp_hh) << W)
                  + ((PW'(pp_lh) + PW'(pp_hl)) << H)
                  + PW'(pp_ll);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= combined;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign p_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/mvm_side_pipe.sv
// Valid / end-of-row tags aligned with the multiplier latency.
module mvm_side_pipe
  import mvm_pkg::*;
#(
  parameter int unsigned STAGES = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  side_t tag_i,
  output side_t tag_o
);
  side_t sp_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) sp_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < STAGES; i++) sp_q[i] <= '0;
    end else begin
      sp_q[0] <= tag_i;
      for (int i = 1; i < STAGES; i++) sp_q[i] <= sp_q[i-1];
    end
  end

  assign tag_o = sp_q[STAGES-1];
endmodule

// File: rtl/mvm_accum.sv
module mvm_accum #(
  parameter int unsigned PW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          add_i,
  input  logic          last_i,
  input  logic [PW-1:0] prod_i,
  output logic          result_valid_o,
  output logic [PW-1:0] result_o
);
  logic [PW-1:0] acc_q, res_q, sum;
  logic          rv_q;

  assign sum = acc_q + prod_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
      rv_q  <= 1'b0;
    end else if (clear_i) begin
      acc_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (add_i) begin
        if (last_i) begin
          res_q <= sum;
          rv_q  <= 1'b1;
          acc_q <= '0;  // next row starts clean, no bubble
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  assign result_valid_o = rv_q;
  assign result_o       = res_q;
endmodule

// File: rtl/mvm_row_mac.sv
module mvm_row_mac
  import mvm_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter int unsigned W       = 32,
  parameter int unsigned STAGES  = 6,
  localparam int unsigned AW     = $clog2(N),
  localparam int unsigned PW     = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          mat_valid_i,
  input  logic [W-1:0]  mat_data_i,
  output logic [AW-1:0] vec_addr_o,
  input  logic [W-1:0]  vec_data_i,
  output logic          result_valid_o,
  output logic [PW-1:0] result_o
);
  logic          accept;
  logic          row_end;
  side_t         tag_in, tag_out;
  logic [PW-1:0] prod;

  assign accept = mat_valid_i && !clear_i;

  mvm_addr_ctr #(.N(N), .AW(AW)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .step_i   (accept),
    .addr_o   (vec_addr_o),
    .at_end_o (row_end)
  );

  mvm_mul_pipe #(.W(W), .STAGES(STAGES)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (mat_data_i),
    .b_i    (vec_data_i),
    .p_o    (prod)
  );

  assign tag_in.valid = accept;
  assign tag_in.last  = accept && row_end;

  mvm_side_pipe #(.STAGES(STAGES)) u_side (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (clear_i),
    .tag_i   (tag_in),
    .tag_o   (tag_out)
  );

  mvm_accum #(.PW(PW)) u_acc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (clear_i),
    .add_i          (tag_out.valid),
    .last_i         (tag_out.last),
    .prod_i         (prod),
    .result_valid_o (result_valid_o),
    .result_o       (result_o)
  );
endmodule

// File: rtl/mvm_row_mac_chk.sv
module mvm_row_mac_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned PW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clear_i,
  input logic          mat_valid_i,
  input logic [AW-1:0] vec_addr_o,
  input logic          result_valid_o,
  input logic [PW-1:0] result_o
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!result_valid_o && vec_addr_o == '0 && result_o == '0));

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mat_valid_i && !clear_i) |=>
      vec_addr_o == (($past(vec_addr_o) == AW'(N - 1)) ? '0 : $past(vec_addr_o) + 1'b1));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mat_valid_i && !clear_i) |=> $stable(vec_addr_o));

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_clear_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (vec_addr_o == '0 && !result_valid_o));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o));
endmodule

bind mvm_row_mac mvm_row_mac_chk #(.N(N), .AW(AW), .PW(PW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .mat_valid_i    (mat_valid_i),
  .vec_addr_o     (vec_addr_o),
  .result_valid_o (result_valid_o),
  .result_o       (result_o)
);

// File: tb/mvm_row_mac_bench.sv
`timescale 1ns/1ps
module mvm_row_mac_bench;
  localparam int N      = 8;
  localparam int AW     = $clog2(N);
  localparam int LAT    = 7;  // R4: edges from accept to result

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          mat_valid = 1'b0;
  logic [31:0]   mat_data = '0;
  logic [AW-1:0] vec_addr;
  logic [31:0]   vec_data;
  logic          res_valid;
  logic [63:0]   res;

  logic [31:0] vec_mem [N];
  assign vec_data = vec_mem[vec_addr];

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [63:0] exp_val_q [$];
  int          exp_cyc_q [$];
  int          exp_idx = 0;
  logic [63:0] exp_acc = '0;
  logic [63:0] last_res = '0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mvm_row_mac #(.N(N)) u_mvm_row_mac (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .clear_i        (clear),
    .mat_valid_i    (mat_valid),
    .mat_data_i     (mat_data),
    .vec_addr_o     (vec_addr),
    .vec_data_i     (vec_data),
    .result_valid_o (res_valid),
    .result_o       (res)
  );

  function automatic logic [63:0] mul64(input logic [31:0] a, input logic [31:0] b);
    return 64'(a) * 64'(b);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Result monitor: R3/R4/R5/R8 values and timing, R9 hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (exp_val_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 actual=unexpected pulse %0h expected=none", res);
        end else begin
          chk("R3 row sum", res, exp_val_q.pop_front());
          chk("R4 latency", 64'(cyc), 64'(exp_cyc_q.pop_front()));
        end
        last_res = res;
      end else begin
        chk("R9 hold", res, last_res);
      end
    end
  end

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    chk("R2 address", 64'(vec_addr), 64'(exp_idx));
    mat_valid = 1'b1;
    mat_data  = d;
    exp_acc   = exp_acc + mul64(d, vec_mem[exp_idx]);
    if (exp_idx == N - 1) begin
      exp_val_q.push_back(exp_acc);
      exp_cyc_q.push_back(cyc + LAT);
      exp_acc = '0;
      exp_idx = 0;
    end else begin
      exp_idx++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mat_valid = 1'b0;
      mat_data  = $urandom;  // R6: data ignored when not valid
      @(posedge clk);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear     = 1'b1;
    mat_valid = 1'b1;  // R7: ignored
    mat_data  = 32'hDEAD_BEEF;
    @(posedge clk);
    exp_val_q.delete();
    exp_cyc_q.delete();
    exp_idx = 0;
    exp_acc = '0;
    @(negedge clk);
    clear     = 1'b0;
    mat_valid = 1'b0;
    chk("R7 address after clear", 64'(vec_addr), 64'd0);
  endtask

  task automatic drain();
    idle(LAT + 4);
    chk("R4 all rows reported", 64'(exp_val_q.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) vec_mem[i] = $urandom;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(res_valid), 64'd0);
    chk("R1 result in reset", res, 64'd0);
    chk("R1 address in reset", 64'(vec_addr), 64'd0);
    rst_n = 1'b1;

    // R3: single row, small values
    for (int i = 0; i < N; i++) send(32'(i + 1));
    drain();

    // R5: back-to-back rows without gaps
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < N; i++) send($urandom);
    drain();

    // R6: random idle cycles inside rows
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < N; i++) begin
        send($urandom);
        if ($urandom_range(3) == 0) idle($urandom_range(2, 1));
      end
    drain();

    // R7: clear in mid-row with products in flight, then a clean row
    for (int i = 0; i < N + 3; i++) send($urandom);
    do_clear();
    idle(LAT + 2);
    for (int i = 0; i < N; i++) send($urandom);
    drain();

    // R7: clear right after a row's last element, before its result
    for (int i = 0; i < N; i++) send($urandom);
    do_clear();
    drain();

    // R8: all-ones operands overflow the 64-bit sum
    for (int i = 0; i < N; i++) vec_mem[i] = 32'hFFFF_FFFF;
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < N; i++) send(32'hFFFF_FFFF);
    drain();

    // Mixed extremes and zeros
    for (int i = 0; i < N; i++) vec_mem[i] = $urandom;
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < N; i++) begin
        case ($urandom_range(3))
          0: send(32'h0);
          1: send(32'hFFFF_FFFF);
          default: send($urandom);
        endcase
      end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule